// File: doc/BRIEF.md
# Control and Status Register with Message Timestamp Counter

This block holds the first control and status byte of a bus controller for a CAN network, together with the free-running counter that stamps each message with a time value. Software reads and writes the byte through a single-cycle write port. The readback value is always available. Three fields belong to hardware: a sticky received-frame flag, a receiver-busy bit and a bus-synchronized bit. Three fields belong to software: a wait-mode clock-stop enable, a wake-up enable and a timer enable.

When the timer is enabled, a 16-bit counter advances on each bit-time tick. Each time a frame is acknowledged on the bus, the counter's current value is latched into the timestamp slot for the receive buffer or for the transmit buffer. The slot is chosen by a select input. When the timer is disabled, the counter returns to zero. The timer cannot be enabled while the controller is in initialization mode.

Top module: `ctl_status_tstamp`

## Requirements
- R1: After reset every stored field is 0 and the counter and both timestamp slots are 0. The readback byte has this layout: bit 7 is the received-frame flag, bit 6 is receiver busy, bit 5 is wait-stop, bit 4 is synchronized, bit 3 is timer enable, bit 2 is wake-up enable, and bits 1:0 read 0.
- R2: A valid-frame pulse sets the received-frame flag. The flag stays set until a write with bit 7 equal to 1 clears it. A write with bit 7 equal to 0 leaves it unchanged. If a valid-frame pulse and a clearing write occur in the same cycle, the flag ends up set.
- R3: While loopback is asserted, bits 7 and 6 of the readback both read 0, and valid-frame pulses do not set the flag.
- R4: Bit 6 reads the receiver-busy input and bit 4 reads the synchronized input in the same cycle. Writes do not affect either bit.
- R5: While the timer is enabled, the counter increases by 1 on each cycle in which the bit tick is high. It wraps from 0xFFFF to 0x0000.
- R6: While the timer enable is 0, the counter is held at 0.
- R7: An acknowledge pulse while the timer is enabled loads the counter value into the slot for the receive buffer when the select is 0, or for the transmit buffer when the select is 1. The other slot is left unchanged. An acknowledge pulse while the timer is disabled changes neither slot.
- R8: While initialization mode is asserted, bit 3 reads 0, the stored timer enable is cleared, and writes cannot set it.
- R9: Bits 5 and 2 are read/write. Their stored values drive the wait-stop output and the wake-up enable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| frame_ok | input | 1 | Valid frame received pulse |
| rx_busy | input | 1 | Receiver front end is receiving |
| bus_sync | input | 1 | Controller is synchronized to the bus |
| bit_tick | input | 1 | One pulse per bit time |
| ack_pulse | input | 1 | Frame acknowledged on the bus |
| ack_sel | input | 1 | Buffer select for the timestamp: 0 receive, 1 transmit |
| init_mode | input | 1 | Initialization mode active |
| lpbk_mode | input | 1 | Loopback mode active |
| reg_q | output | 8 | Register readback |
| wait_stop | output | 1 | Stop bus-interface clocks in wait mode |
| wake_en | output | 1 | Allow restart from sleep on bus traffic |
| ts_rx | output | 16 | Timestamp captured for the receive buffer |
| ts_tx | output | 16 | Timestamp captured for the transmit buffer |

## Verification
The assertions check the following on every cycle:
- The flag is cleared under loopback.
- A valid-frame pulse always wins over a clearing write.
- Initialization mode clears the timer enable.
- The counter is zero whenever the timer is disabled, and it steps by one per tick while enabled.
- Each acknowledge loads the selected slot.

Some behaviour is shown only by the bench's scenarios, which compare the outputs against a cycle model:
- The wrap from 0xFFFF to zero, reached with a long directed tick run.
- A write of 0 to bit 7 leaving the flag alone.
- The unselected slot holding its value.
- The same-cycle readback of the status inputs.

// File: rtl/ctl_status_tstamp.sv
module ctl_status_tstamp #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            frame_ok,
  input  logic            rx_busy,
  input  logic            bus_sync,
  input  logic            bit_tick,
  input  logic            ack_pulse,
  input  logic            ack_sel,
  input  logic            init_mode,
  input  logic            lpbk_mode,
  output logic [7:0]      reg_q,
  output logic            wait_stop,
  output logic            wake_en,
  output logic [TS_W-1:0] ts_rx,
  output logic [TS_W-1:0] ts_tx
);
  localparam int B_FLAG = 7;
  localparam int B_BUSY = 6;
  localparam int B_WS   = 5;
  localparam int B_SYNC = 4;
  localparam int B_TEN  = 3;
  localparam int B_WK   = 2;

  logic            flag_q, ws_q, ten_q, wk_q;
  logic [TS_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ws_q   <= 1'b0;
      ten_q  <= 1'b0;
      wk_q   <= 1'b0;
    end else begin
      if (lpbk_mode)                   flag_q <= 1'b0;
      else if (frame_ok)               flag_q <= 1'b1;
      else if (wr_en && wr_data[B_FLAG]) flag_q <= 1'b0;
      if (wr_en) begin
        ws_q <= wr_data[B_WS];
        wk_q <= wr_data[B_WK];
      end
      if (init_mode)  ten_q <= 1'b0;
      else if (wr_en) ten_q <= wr_data[B_TEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!ten_q)    cnt_q <= '0;
    else if (bit_tick)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_rx <= '0;
      ts_tx <= '0;
    end else if (ack_pulse && ten_q) begin
      if (ack_sel) ts_tx <= cnt_q;
      else         ts_rx <= cnt_q;
    end
  end

  assign reg_q = {flag_q & ~lpbk_mode, rx_busy & ~lpbk_mode, ws_q, bus_sync,
                  ten_q & ~init_mode, wk_q, 2'b00};
  assign wait_stop = ws_q;
  assign wake_en   = wk_q;

  p_lpbk_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lpbk_mode |=> !flag_q);
  p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !lpbk_mode) |=> reg_q[B_FLAG] || lpbk_mode);
  p_init_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_mode |=> !ten_q);
  p_cnt_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ten_q |=> cnt_q == '0);
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ten_q && bit_tick) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_cap_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pulse && ten_q && !ack_sel) |=> ts_rx == $past(cnt_q));
  p_cap_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pulse && ten_q && ack_sel) |=> ts_tx == $past(cnt_q));
endmodule

// File: tb/sim_ctl_status_tstamp.sv
module sim_ctl_status_tstamp;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, frame_ok = 0, rx_busy = 0, bus_sync = 0, bit_tick = 0;
  logic ack_pulse = 0, ack_sel = 0, init_mode = 0, lpbk_mode = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] reg_q;
  logic wait_stop, wake_en;
  logic [15:0] ts_rx, ts_tx;

  int total = 0, bad = 0;
  bit m_flag, m_ws, m_ten, m_wk;
  logic [15:0] m_cnt, m_rx, m_tx;

  ctl_status_tstamp u0 (.clk, .rst_n, .wr_en, .wr_data, .frame_ok, .rx_busy,
    .bus_sync, .bit_tick, .ack_pulse, .ack_sel, .init_mode, .lpbk_mode,
    .reg_q, .wait_stop, .wake_en, .ts_rx, .ts_tx);

  always #5 clk = ~clk;

  function automatic logic [7:0] exp_reg();
    return {m_flag & ~lpbk_mode, rx_busy & ~lpbk_mode, m_ws, bus_sync,
            m_ten & ~init_mode, m_wk, 2'b00};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [7:0] e;
    e = exp_reg();
    chk("R2 flag", {31'd0, reg_q[7]}, {31'd0, e[7]});
    chk("R4 busy/sync", {30'd0, reg_q[6], reg_q[4]}, {30'd0, e[6], e[4]});
    chk("R8 timer enable", {31'd0, reg_q[3]}, {31'd0, e[3]});
    chk("R9 rw bits", {28'd0, reg_q[5], reg_q[2], wait_stop, wake_en},
        {28'd0, e[5], e[2], e[5], e[2]});
    chk("R1 reserved", {30'd0, reg_q[1:0]}, 32'd0);
    chk("R7 ts_rx", {16'd0, ts_rx}, {16'd0, m_rx});
    chk("R7 ts_tx", {16'd0, ts_tx}, {16'd0, m_tx});
  endtask

  task automatic step();
    #1 check_all();
    @(posedge clk);
    if (ack_pulse && m_ten) begin
      if (ack_sel) m_tx = m_cnt; else m_rx = m_cnt;
    end
    if (!m_ten) m_cnt = 0; else if (bit_tick) m_cnt = m_cnt + 1;
    if (lpbk_mode) m_flag = 0;
    else if (frame_ok) m_flag = 1;
    else if (wr_en && wr_data[7]) m_flag = 0;
    if (wr_en) begin m_ws = wr_data[5]; m_wk = wr_data[2]; end
    if (init_mode) m_ten = 0; else if (wr_en) m_ten = wr_data[3];
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; frame_ok = 0; bit_tick = 0; ack_pulse = 0;
    init_mode = 0; lpbk_mode = 0;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<190000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int seed = 32'h1234;
    void'($urandom(seed));
    m_flag = 0; m_ws = 0; m_ten = 0; m_wk = 0; m_cnt = 0; m_rx = 0; m_tx = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 reset reg", {24'd0, reg_q}, 32'd0);
    chk("R1 reset ts", {ts_rx, ts_tx}, 32'd0);
    @(negedge clk);

    // R2 set, write 0 ignored, same-cycle set wins, write 1 clears
    frame_ok = 1; step(); idle();
    wr_en = 1; wr_data = 8'h00; step(); idle();
    #1 chk("R2 write0 keeps flag", {31'd0, reg_q[7]}, 32'd1);
    wr_en = 1; wr_data = 8'h80; frame_ok = 1; step(); idle();
    #1 chk("R2 set wins", {31'd0, reg_q[7]}, 32'd1);
    wr_en = 1; wr_data = 8'h80; step(); idle();
    #1 chk("R2 w1c", {31'd0, reg_q[7]}, 32'd0);

    // R3 loopback masks busy and blocks set
    lpbk_mode = 1; rx_busy = 1; frame_ok = 1; step();
    #1 chk("R3 loopback bits", {30'd0, reg_q[7:6]}, 32'd0);
    idle(); rx_busy = 0;

    // R8 init blocks the enable
    init_mode = 1; wr_en = 1; wr_data = 8'h08; step();
    #1 chk("R8 init blocks", {31'd0, reg_q[3]}, 32'd0);
    idle();

    // R5 wrap, R7 capture, R6 clear on disable
    wr_en = 1; wr_data = 8'h08; step(); idle();
    bit_tick = 1;
    repeat (65535) step();
    bit_tick = 0; ack_pulse = 1; ack_sel = 0; step(); idle();
    #1 chk("R5 reach max", {16'd0, ts_rx}, 32'h0000FFFF);
    bit_tick = 1; step(); idle();
    ack_pulse = 1; ack_sel = 1; step(); idle();
    #1 chk("R5 wrap to zero", {16'd0, ts_tx}, 32'd0);
    chk("R7 other slot kept", {16'd0, ts_rx}, 32'h0000FFFF);
    wr_en = 1; wr_data = 8'h00; step(); idle();
    wr_en = 1; wr_data = 8'h08; step(); idle();
    ack_pulse = 1; ack_sel = 0; step(); idle();
    #1 chk("R6 cleared on disable", {16'd0, ts_rx}, 32'd0);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      wr_en     = ($urandom % 8) == 0;
      wr_data   = 8'($urandom);
      if (($urandom % 4) != 0) wr_data[3] = 1'b1;
      frame_ok  = ($urandom % 6) == 0;
      rx_busy   = 1'($urandom);
      bus_sync  = 1'($urandom);
      bit_tick  = 1'($urandom);
      ack_pulse = ($urandom % 5) == 0;
      ack_sel   = 1'($urandom);
      init_mode = ($urandom % 20) == 0;
      lpbk_mode = ($urandom % 12) == 0;
      step();
    end
    idle(); step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule